// File: doc/BRIEF.md
# Triggered Shadow Control Register Bank

This block is the register file that sits behind a serial control slave. A one-byte gain and bias control word is written into a shadow copy. It reaches the active copy, which drives the analog control byte, in one of two ways. Either all trigger masks are clear, so the write goes straight through, or a trigger bit whose mask is set is written. A control register holds the power-mode bit, three trigger masks, three self-clearing triggers and a self-clearing powered-reset bit. Further registers hold the identification bytes, a revision byte, a group slave ID and a software-reset bit.

A small state machine tracks power state. After the supply-good reset it passes from startup through active and settles in low power. A later write of the power-mode bit moves it between active and low power. A powered reset or a software reset restarts the same sequence and returns the non-protocol registers to their defaults. The active control byte is still held while the block is in low power.

The register port is a single write strobe with address, data and a broadcast qualifier, plus a combinational read address and read data.

Top module: `trig_ctrl_bank`

## Requirements
- R1: While rst_n is low, ctrl_byte is 8'h00 and low_power is 1. Reads return these values: 0x00 gives 8'h00, 0x1C gives 8'h80, 0x1D gives 8'h0E, 0x1E gives 8'h1A, 0x1F gives {2'b00, 2'b01, slave_id}, 0x20 gives 8'h00, 0x21 gives 8'h10, 0x22 gives 8'h00 and 0x23 gives 8'h00. Unmapped addresses read 8'h00.
- R2: The power state goes from startup to active on the first clock edge after a reset, then to the state chosen by the power-mode bit. The power-mode bit is 0x1C bit 7: 1 selects low power and 0 selects active. low_power is 0 only in the active state. A write of the power-mode bit changes low_power at that write's clock edge.
- R3: Suppose all three trigger masks are 0. A write to 0x00 then updates both the shadow copy and ctrl_byte at the write's edge.
- R4: Suppose any trigger mask is 1. A write to 0x00 then updates only the shadow copy, and ctrl_byte holds. A read of 0x00 always returns the shadow copy.
- R5: Trigger i is 0x1C bit i, and mask i is 0x1C bit 3+i, for i from 0 to 2. A write to 0x1C copies the shadow copy to ctrl_byte when it has trigger i = 1 and mask i = 1 in the same byte, for some i. A trigger written 1 with its mask 0, or a trigger written 0, has no effect.
- R6: Reads of 0x1C return {power-mode, 0, mask2, mask1, mask0, 3'b000}. Trigger bits and the powered-reset bit always read back as 0.
- R7: A write to 0x1C with bit 6 = 1 is a powered reset, and it overrides the other bits of that byte. On the next edge the shadow copy, ctrl_byte and the masks become 0 and the power-mode bit becomes 1. The state then restarts at startup.
- R8: A write to 0x23 with bit 7 = 1 is a software reset. It has the same effect as R7, but the group slave ID at 0x22 is kept.
- R9: A write with wr_bcast = 1 takes effect only at 0x1C. At any other address it is ignored.
- R10: Writes to 0x1D, 0x1E, 0x1F, 0x20 and 0x21 are ignored.
- R11: Bits 7:4 of 0x22 are read/write and hold the group slave ID. Bits 3:0 read as 0. Only rst_n clears the group slave ID.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Supply-good reset, active low |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_bcast | input | 1 | Write came from a broadcast or group address |
| wr_addr | input | 8 | Write register address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 8 | Read register address |
| rd_data | output | 8 | Read data, combinational |
| slave_id | input | 4 | Slave ID shown in 0x1F bits 3:0 |
| ctrl_byte | output | 8 | Active control byte |
| low_power | output | 1 | High unless in the active power state |

## Verification
The powered-reset bit and the trigger bits share one byte, so a single write can ask for a shadow transfer and a reset in the same cycle. The bench provokes this by writing 8'h7F, which carries the reset bit together with every mask and every trigger, after loading a nonzero shadow value. The reset must win: ctrl_byte must read 0 rather than the shadow value, the masks must read back clear, and the state must restart. Random writes to 0x1C that now and then carry bit 6 create this collision again, and an independent register model judges each outcome.

// File: rtl/tcb_pkg.sv
package tcb_pkg;
    localparam logic [7:0] A_CTRL  = 8'h00;
    localparam logic [7:0] A_PM    = 8'h1C;
    localparam logic [7:0] A_PROD  = 8'h1D;
    localparam logic [7:0] A_MANL  = 8'h1E;
    localparam logic [7:0] A_MANH  = 8'h1F;
    localparam logic [7:0] A_EXTP  = 8'h20;
    localparam logic [7:0] A_REV   = 8'h21;
    localparam logic [7:0] A_GSID  = 8'h22;
    localparam logic [7:0] A_SWRST = 8'h23;

    localparam logic [7:0] PROD_ID  = 8'h0E;
    localparam logic [7:0] MANL_ID  = 8'h1A;
    localparam logic [1:0] MANH_ID  = 2'b01;
    localparam logic [7:0] EXTP_ID  = 8'h00;
    localparam logic [7:0] REV_ID   = 8'h10;

    typedef enum logic [1:0] {
        PS_START  = 2'd0,
        PS_ACTIVE = 2'd1,
        PS_LOW    = 2'd2
    } pwr_state_t;
endpackage

// File: rtl/tcb_trigger_unit.sv
module tcb_trigger_unit #(
    parameter int DATA_W   = 8,
    parameter int NUM_TRIG = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clear,
    input  logic                data_wr,
    input  logic [DATA_W-1:0]   data_in,
    input  logic                ctl_wr,
    input  logic [NUM_TRIG-1:0] mask_in,
    input  logic [NUM_TRIG-1:0] trig_in,
    output logic [DATA_W-1:0]   shadow_o,
    output logic [DATA_W-1:0]   active_o,
    output logic [NUM_TRIG-1:0] mask_o
);
    typedef struct packed {
        logic [DATA_W-1:0]   shadow;
        logic [DATA_W-1:0]   active;
        logic [NUM_TRIG-1:0] mask;
    } trig_st_t;

    trig_st_t            st_d, st_q;
    logic [NUM_TRIG-1:0] fire;

    for (genvar i = 0; i < NUM_TRIG; i++) begin : g_fire
        assign fire[i] = trig_in[i] & mask_in[i];
    end

    always_comb begin
        st_d = st_q;
        if (clear) begin
            st_d = '0;
        end else begin
            if (data_wr) begin
                st_d.shadow = data_in;
                if (st_q.mask == '0) begin
                    st_d.active = data_in;
                end
            end
            if (ctl_wr) begin
                st_d.mask = mask_in;
                if (|fire) begin
                    st_d.active = st_q.shadow;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign shadow_o = st_q.shadow;
    assign active_o = st_q.active;
    assign mask_o   = st_q.mask;

    p_plain_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && !clear && st_q.mask == '0) |=> (active_o == $past(data_in)));

    p_masked_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && !ctl_wr && !clear && st_q.mask != '0) |=> (active_o == $past(active_o)));

    p_fire_copy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && !data_wr && !clear && |(trig_in & mask_in)) |=> (active_o == $past(shadow_o)));

    p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (active_o == '0 && shadow_o == '0 && mask_o == '0));
endmodule

// File: rtl/tcb_power_fsm.sv
module tcb_power_fsm
    import tcb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic pm_wr,
    input  logic pm_in,
    output logic pm_o,
    output logic low_power_o
);
    typedef struct packed {
        pwr_state_t state;
        logic       pm;
    } pwr_st_t;

    pwr_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (restart) begin
            st_d.pm    = 1'b1;
            st_d.state = PS_START;
        end else begin
            if (pm_wr) begin
                st_d.pm = pm_in;
            end
            if (st_q.state == PS_START) begin
                st_d.state = PS_ACTIVE;
            end else begin
                st_d.state = st_d.pm ? PS_LOW : PS_ACTIVE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.state <= PS_START;
            st_q.pm    <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign pm_o        = st_q.pm;
    assign low_power_o = (st_q.state != PS_ACTIVE);

    p_start_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.state == PS_START && !restart) |=> (st_q.state == PS_ACTIVE));

    p_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (st_q.state == PS_START && pm_o));

    p_settle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.state != PS_START && !restart && !pm_wr) |=> (low_power_o == $past(pm_o)));
endmodule

// File: rtl/tcb_read_mux.sv
module tcb_read_mux
    import tcb_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 8,
    parameter int NUM_TRIG = 3
) (
    input  logic [ADDR_W-1:0]   rd_addr,
    input  logic [DATA_W-1:0]   shadow,
    input  logic                pm,
    input  logic [NUM_TRIG-1:0] mask,
    input  logic [3:0]          gsid,
    input  logic [3:0]          slave_id,
    output logic [DATA_W-1:0]   rd_data
);
    localparam int MASK_LSB = NUM_TRIG;
    localparam int PM_BIT   = 2 * NUM_TRIG + 1;

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            ADDR_W'(A_CTRL): rd_data = shadow;
            ADDR_W'(A_PM): begin
                rd_data[PM_BIT] = pm;
                rd_data[MASK_LSB +: NUM_TRIG] = mask;
            end
            ADDR_W'(A_PROD): rd_data = DATA_W'(PROD_ID);
            ADDR_W'(A_MANL): rd_data = DATA_W'(MANL_ID);
            ADDR_W'(A_MANH): rd_data = DATA_W'({2'b00, MANH_ID, slave_id});
            ADDR_W'(A_EXTP): rd_data = DATA_W'(EXTP_ID);
            ADDR_W'(A_REV):  rd_data = DATA_W'(REV_ID);
            ADDR_W'(A_GSID): rd_data = DATA_W'({gsid, 4'h0});
            default:         rd_data = '0;
        endcase
    end
endmodule

// File: rtl/trig_ctrl_bank.sv
module trig_ctrl_bank
    import tcb_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 8,
    parameter int NUM_TRIG = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_bcast,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic [3:0]        slave_id,
    output logic [DATA_W-1:0] ctrl_byte,
    output logic              low_power
);
    localparam int MASK_LSB = NUM_TRIG;
    localparam int PRST_BIT = 2 * NUM_TRIG;
    localparam int PM_BIT   = 2 * NUM_TRIG + 1;
    localparam int SWR_BIT  = DATA_W - 1;

    typedef struct packed {
        logic [3:0] gsid;
    } top_st_t;

    top_st_t             st_d, st_q;
    logic                acc, hit_ctrl, hit_pm, hit_gsid, hit_swr;
    logic                restart, pm_wr, data_wr;
    logic [DATA_W-1:0]   shadow;
    logic [NUM_TRIG-1:0] mask;
    logic                pm;

    always_comb begin
        acc      = wr_en && (!wr_bcast || wr_addr == ADDR_W'(A_PM));
        hit_ctrl = acc && wr_addr == ADDR_W'(A_CTRL);
        hit_pm   = acc && wr_addr == ADDR_W'(A_PM);
        hit_gsid = acc && wr_addr == ADDR_W'(A_GSID);
        hit_swr  = acc && wr_addr == ADDR_W'(A_SWRST);
        restart  = (hit_pm && wr_data[PRST_BIT]) || (hit_swr && wr_data[SWR_BIT]);
        pm_wr    = hit_pm && !wr_data[PRST_BIT];
        data_wr  = hit_ctrl;
        st_d     = st_q;
        if (hit_gsid) begin
            st_d.gsid = wr_data[DATA_W-1 -: 4];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    tcb_trigger_unit #(
        .DATA_W   (DATA_W),
        .NUM_TRIG (NUM_TRIG)
    ) u_trig (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (restart),
        .data_wr  (data_wr),
        .data_in  (wr_data),
        .ctl_wr   (pm_wr),
        .mask_in  (wr_data[MASK_LSB +: NUM_TRIG]),
        .trig_in  (wr_data[NUM_TRIG-1:0]),
        .shadow_o (shadow),
        .active_o (ctrl_byte),
        .mask_o   (mask)
    );

    tcb_power_fsm u_pwr (
        .clk         (clk),
        .rst_n       (rst_n),
        .restart     (restart),
        .pm_wr       (pm_wr),
        .pm_in       (wr_data[PM_BIT]),
        .pm_o        (pm),
        .low_power_o (low_power)
    );

    tcb_read_mux #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .NUM_TRIG (NUM_TRIG)
    ) u_rd (
        .rd_addr  (rd_addr),
        .shadow   (shadow),
        .pm       (pm),
        .mask     (mask),
        .gsid     (st_q.gsid),
        .slave_id (slave_id),
        .rd_data  (rd_data)
    );

    p_gsid_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_bcast && wr_addr == ADDR_W'(A_SWRST)) |=> $stable(st_q.gsid));

    p_bcast_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_bcast && wr_addr != ADDR_W'(A_PM)) |=> ($stable(ctrl_byte) && $stable(st_q.gsid)));

    p_gsid_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_bcast && wr_addr == ADDR_W'(A_GSID)) |=> (st_q.gsid == $past(wr_data[DATA_W-1 -: 4])));
endmodule

// File: tb/trig_ctrl_bank_tb.sv
module trig_ctrl_bank_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0, wr_bcast = 1'b0;
    logic [7:0] wr_addr = 8'h00, wr_data = 8'h00, rd_addr = 8'h00;
    logic [7:0] rd_data, ctrl_byte;
    logic [3:0] slave_id = 4'h9;
    logic       low_power;

    int n_chk = 0, n_fail = 0;

    // model state
    logic [7:0] m_sh = 8'h00, m_act = 8'h00;
    logic [2:0] m_mask = 3'b000;
    logic       m_pm = 1'b1;
    logic [3:0] m_gsid = 4'h0;
    int         m_st = 0; // 0 startup, 1 active, 2 low power

    always #2.5 clk = ~clk;

    trig_ctrl_bank u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_bcast(wr_bcast),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .slave_id(slave_id), .ctrl_byte(ctrl_byte), .low_power(low_power)
    );

    function automatic logic [7:0] exp_read(input logic [7:0] a);
        case (a)
            8'h00: return m_sh;
            8'h1C: return {m_pm, 1'b0, m_mask, 3'b000};
            8'h1D: return 8'h0E;
            8'h1E: return 8'h1A;
            8'h1F: return {4'b0001, slave_id};
            8'h21: return 8'h10;
            8'h22: return {m_gsid, 4'h0};
            default: return 8'h00;
        endcase
    endfunction

    task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic model_edge(input bit we, input bit bc, input logic [7:0] a, input logic [7:0] d);
        bit rs = 1'b0;
        if (we && (!bc || a == 8'h1C)) begin
            case (a)
                8'h00: begin m_sh = d; if (m_mask == 3'b000) m_act = d; end
                8'h1C: begin
                    if (d[6]) rs = 1'b1;
                    else begin
                        m_pm = d[7];
                        m_mask = d[5:3];
                        if ((d[2:0] & d[5:3]) != 3'b000) m_act = m_sh;
                    end
                end
                8'h22: m_gsid = d[7:4];
                8'h23: if (d[7]) rs = 1'b1;
                default: ;
            endcase
        end
        if (rs) begin
            m_sh = 8'h00; m_act = 8'h00; m_mask = 3'b000; m_pm = 1'b1; m_st = 0;
        end else if (m_st == 0) m_st = 1;
        else m_st = m_pm ? 2 : 1;
    endtask

    task automatic step(input string tag, input bit we, input bit bc, input logic [7:0] a,
                        input logic [7:0] d, input logic [7:0] ra);
        wr_en = we; wr_bcast = bc; wr_addr = a; wr_data = d;
        @(posedge clk);
        model_edge(we, bc, a, d);
        @(negedge clk);
        wr_en = 1'b0; wr_bcast = 1'b0;
        rd_addr = ra;
        #1;
        chk(tag, "ctrl_byte", ctrl_byte, m_act);
        chk(tag, "low_power", {7'b0, low_power}, {7'b0, m_st != 1});
        chk(tag, "rd_data", rd_data, exp_read(ra));
    endtask

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [7:0] ids [10];
        void'($urandom(32'd20240611));
        ids = '{8'h00, 8'h1C, 8'h1D, 8'h1E, 8'h1F, 8'h20, 8'h21, 8'h22, 8'h23, 8'h55};
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", "ctrl_byte", ctrl_byte, 8'h00);
        chk("R1", "low_power", {7'b0, low_power}, 8'h01);
        for (int i = 0; i < 10; i++) begin
            rd_addr = ids[i];
            #1;
            chk("R1", $sformatf("read %h", ids[i]), rd_data, exp_read(ids[i]));
        end
        rst_n = 1'b1;
        // R2 startup -> active -> low power
        step("R2", 0, 0, 8'h00, 8'h00, 8'h1C);
        step("R2", 0, 0, 8'h00, 8'h00, 8'h1C);
        step("R2", 1, 0, 8'h1C, 8'h00, 8'h1C);
        // R3 plain write
        step("R3", 1, 0, 8'h00, 8'h5A, 8'h00);
        // R4 masked write holds in shadow
        step("R6", 1, 0, 8'h1C, 8'h08, 8'h1C);
        step("R4", 1, 0, 8'h00, 8'hC3, 8'h00);
        // R5 masked trigger no effect, zero trigger no effect, then fire
        step("R5", 1, 0, 8'h1C, 8'h0A, 8'h1C);
        step("R5", 1, 0, 8'h1C, 8'h08, 8'h1C);
        step("R5", 1, 0, 8'h1C, 8'h09, 8'h1C);
        // R11 group slave id
        step("R11", 1, 0, 8'h22, 8'hA7, 8'h22);
        // R10 identification writes ignored
        step("R10", 1, 0, 8'h1D, 8'hFF, 8'h1D);
        step("R10", 1, 0, 8'h21, 8'hFF, 8'h21);
        step("R10", 1, 0, 8'h1F, 8'hFF, 8'h1F);
        // R9 broadcast only to 0x1C
        step("R9", 1, 1, 8'h00, 8'h11, 8'h00);
        step("R9", 1, 1, 8'h22, 8'h30, 8'h22);
        step("R9", 1, 1, 8'h1C, 8'h80, 8'h1C);
        // R7 powered reset wins over triggers in the same byte
        step("R7", 1, 0, 8'h1C, 8'h38, 8'h1C);
        step("R7", 1, 0, 8'h00, 8'h66, 8'h00);
        step("R7", 1, 0, 8'h1C, 8'h7F, 8'h1C);
        step("R7", 0, 0, 8'h00, 8'h00, 8'h00);
        step("R7", 0, 0, 8'h00, 8'h00, 8'h1C);
        // R8 software reset keeps group slave id
        step("R8", 1, 0, 8'h00, 8'h3C, 8'h00);
        step("R8", 1, 0, 8'h23, 8'h80, 8'h22);
        step("R8", 0, 0, 8'h00, 8'h00, 8'h00);
        step("R8", 1, 0, 8'h23, 8'h7F, 8'h1C);
        // random mix
        for (int k = 0; k < 1500; k++) begin
            logic [7:0] a, d, ra;
            bit we, bc;
            a  = ids[$urandom % 10];
            ra = ids[$urandom % 10];
            d  = 8'($urandom);
            if (a == 8'h1C && ($urandom % 6) != 0) d[6] = 1'b0;
            if (a == 8'h23 && ($urandom % 6) != 0) d[7] = 1'b0;
            we = ($urandom % 4) != 0;
            bc = ($urandom % 8) == 0;
            step("R5", we, bc, a, d, ra);
        end
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule